// File: doc/BRIEF.md
# Deferred Slice Buffer with Ordered Wakeup

This block parks micro-ops that depend on an outstanding data-cache load miss. As such poisoned micro-ops pseudo-retire in program order, retirement writes them into the buffer one at a time. Each entry keeps the micro-op's opcode word, the memory sequence ID it received at fetch, and the one source operand that may already be computed. A micro-op has at most two sources and at least one of them is poisoned, so one captured value is enough. Entries that are load misses also carry a miss tag.

Several load misses and their dependent chains can sit in the buffer at the same time. The memory system reports returned miss data by tag, in any order. The buffer records each returned tag in a ready table. Reissue is strictly in program order. A load-miss entry at the head waits until its tag is marked ready. Every entry behind it waits too, even when a later miss has already returned. Non-load entries at the head issue as soon as the pipeline accepts them.

Reissue goes on until the buffer is empty. An empty buffer tells the core that the two register contexts may be merged. A mispredicted branch or an exception during dependent execution asserts flush, which drops every entry and every ready mark.

Top module: `dslice_buf`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `iss_valid`=0 and `enq_ready`=1.
- R2: `full` and `enq_ready`=0 hold exactly when DEPTH (32) entries are held. An enqueue offered while full is dropped, even if an issue happens in the same cycle. A full buffer with no issue and no flush stays full.
- R3: Entries leave in the order they were accepted. Each carries `op`, `seq`, `has_val`, `val`, `is_load` and `tag` unchanged.
- R4: A head entry with `is_load`=1 gives `iss_valid`=0 while its tag is not marked ready, and nothing behind it issues. Without a return, a blocked head stays blocked.
- R5: A return for the tag of a later load does not let that load or anything else pass the blocked head. Once the head's tag returns, the later load issues as soon as it reaches the head, with no further wait.
- R6: A return of tag T in cycle N marks T ready from cycle N+1. A load head with tag T shows `iss_valid`=1 in cycle N+1.
- R7: A head entry with `is_load`=0 gives `iss_valid`=1 in the cycle after it is accepted, with no return needed.
- R8: Flush empties the buffer and clears every ready mark for the next cycle. An enqueue offered in the flush cycle is dropped. A load whose tag returned before the flush waits for a new return.
- R9: Issuing a load-miss entry clears the ready mark of its tag. A later load with the same tag waits for a fresh return. A return in the same cycle as that issue leaves the mark set.
- R10: While `iss_valid`=1 and `iss_ready`=0, the head stays valid and its outputs are stable.
- R11: `empty` is 1 exactly when no entry is held. When `empty`=1, `iss_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop all entries and all ready marks |
| enq_valid | input | 1 | Retirement offers a poisoned micro-op |
| enq_ready | output | 1 | Offer will be taken (not full) |
| enq_is_load | input | 1 | Micro-op is a load miss (waits on its tag) |
| enq_tag | input | TAG_W | Miss tag of a load-miss micro-op |
| enq_op | input | OP_W | Opcode/control word |
| enq_seq | input | SEQ_W | Memory sequence ID given at fetch |
| enq_has_val | input | 1 | Captured operand present |
| enq_val | input | DATA_W | Captured source operand |
| ret_valid | input | 1 | Miss data has returned |
| ret_tag | input | TAG_W | Tag of the returned miss |
| iss_valid | output | 1 | Head entry may be reissued |
| iss_ready | input | 1 | Pipeline accepts the head |
| iss_is_load | output | 1 | Head is a load miss |
| iss_tag | output | TAG_W | Head miss tag |
| iss_op | output | OP_W | Head opcode word |
| iss_seq | output | SEQ_W | Head sequence ID |
| iss_has_val | output | 1 | Head carries a captured operand |
| iss_val | output | DATA_W | Head captured operand |
| empty | output | 1 | No entry held (merge may proceed) |
| full | output | 1 | DEPTH entries held |

## Verification
The bound checker looks at every cycle. It checks that a full buffer stays full without an issue or flush, and that a stalled head keeps its outputs. It also checks that a flush leaves the buffer empty, that an empty buffer never offers an issue, and that a blocked load head stays blocked until some return arrives. Only the bench scenarios can show that the order and payload are right across a full fill and drain. They also show that returns arriving out of order leave program order intact, that a ready mark is used up by an issue or wiped by a flush, and the exact one-cycle wake latency. A cycle-level reference model in the bench covers these over a long pseudo-random mix of enqueues, returns, stalls and flushes.

// File: rtl/dslice_pkg.sv
package dslice_pkg;
  localparam int unsigned DEF_DEPTH  = 32;
  localparam int unsigned DEF_TAG_W  = 4;
  localparam int unsigned DEF_OP_W   = 16;
  localparam int unsigned DEF_SEQ_W  = 8;
  localparam int unsigned DEF_DATA_W = 32;

  typedef enum logic {
    KIND_DEP    = 1'b0,
    KIND_LDMISS = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/dslice_ptrs.sv
module dslice_ptrs #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign upd_en = flush | push | pop;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign full   = (cnt_q == CAP);
  assign empty  = (cnt_q == '0);
endmodule

// File: rtl/dslice_store.sv
module dslice_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned ENT_W = 62,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [ENT_W-1:0] rd_ent
);
  logic [ENT_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= wr_ent;
    end
  end

  assign rd_ent = slot_q[rd_ptr];
endmodule

// File: rtl/dslice_wake.sv
module dslice_wake #(
  parameter int unsigned TAG_W = 4,
  localparam int unsigned NTAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_tag,
  input  logic             consume,
  input  logic [TAG_W-1:0] consume_tag,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_ready
);
  logic [NTAG-1:0] rdy_q, rdy_d;
  logic            rdy_en;

  assign rdy_en = flush | ret_valid | consume;

  always_comb begin
    rdy_d = rdy_q;
    if (flush) begin
      rdy_d = '0;
    end else begin
      if (consume)   rdy_d[consume_tag] = 1'b0;
      if (ret_valid) rdy_d[ret_tag]     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= '0;
    else if (rdy_en) rdy_q <= rdy_d;
  end

  assign look_ready = rdy_q[look_tag];
endmodule

// File: rtl/dslice_buf.sv
module dslice_buf
  import dslice_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned TAG_W  = DEF_TAG_W,
  parameter int unsigned OP_W   = DEF_OP_W,
  parameter int unsigned SEQ_W  = DEF_SEQ_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic              enq_is_load,
  input  logic [TAG_W-1:0]  enq_tag,
  input  logic [OP_W-1:0]   enq_op,
  input  logic [SEQ_W-1:0]  enq_seq,
  input  logic              enq_has_val,
  input  logic [DATA_W-1:0] enq_val,
  input  logic              ret_valid,
  input  logic [TAG_W-1:0]  ret_tag,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic              iss_is_load,
  output logic [TAG_W-1:0]  iss_tag,
  output logic [OP_W-1:0]   iss_op,
  output logic [SEQ_W-1:0]  iss_seq,
  output logic              iss_has_val,
  output logic [DATA_W-1:0] iss_val,
  output logic              empty,
  output logic              full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    slot_kind_e          kind;
    logic [TAG_W-1:0]    tag;
    logic [OP_W-1:0]     op;
    logic [SEQ_W-1:0]    seq;
    logic                has_val;
    logic [DATA_W-1:0]   val;
  } slot_t;

  localparam int unsigned ENT_W = $bits(slot_t);

  slot_t            wr_slot, hd_slot;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push, pop, hd_ready, hd_is_ld, empty_i, full_i;

  assign push = enq_valid && !full_i && !flush;
  assign pop  = iss_valid && iss_ready && !flush;

  always_comb begin
    wr_slot.kind    = enq_is_load ? KIND_LDMISS : KIND_DEP;
    wr_slot.tag     = enq_tag;
    wr_slot.op      = enq_op;
    wr_slot.seq     = enq_seq;
    wr_slot.has_val = enq_has_val;
    wr_slot.val     = enq_val;
  end

  dslice_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .full   (full_i),
    .empty  (empty_i)
  );

  dslice_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk    (clk),
    .wr_en  (push),
    .wr_ptr (wr_ptr),
    .wr_ent (wr_slot),
    .rd_ptr (rd_ptr),
    .rd_ent (hd_slot)
  );

  assign hd_is_ld = (hd_slot.kind == KIND_LDMISS);

  dslice_wake #(.TAG_W(TAG_W)) u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .ret_valid   (ret_valid),
    .ret_tag     (ret_tag),
    .consume     (pop && hd_is_ld),
    .consume_tag (hd_slot.tag),
    .look_tag    (hd_slot.tag),
    .look_ready  (hd_ready)
  );

  assign iss_valid   = !empty_i && (!hd_is_ld || hd_ready);
  assign iss_is_load = hd_is_ld;
  assign iss_tag     = hd_slot.tag;
  assign iss_op      = hd_slot.op;
  assign iss_seq     = hd_slot.seq;
  assign iss_has_val = hd_slot.has_val;
  assign iss_val     = hd_slot.val;
  assign empty       = empty_i;
  assign full        = full_i;
  assign enq_ready   = !full_i;
endmodule

// File: rtl/dslice_buf_chk.sv
module dslice_buf_chk #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned SEQ_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              ret_valid,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [OP_W-1:0]   iss_op,
  input logic [SEQ_W-1:0]  iss_seq,
  input logic [DATA_W-1:0] iss_val,
  input logic              empty,
  input logic              full
);
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !(iss_valid && iss_ready) && !flush |=> full) else $error("full dropped"); // R2

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready && !flush |=> iss_valid && $stable(iss_op) && $stable(iss_seq) && $stable(iss_val))
    else $error("stalled head changed"); // R10

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !iss_valid) else $error("flush left entries"); // R8

  AST_EMPTY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !iss_valid) else $error("issue while empty"); // R11

  AST_BLOCK_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    !empty && !iss_valid && !ret_valid && !flush |=> !iss_valid) else $error("blocked head woke alone"); // R4
endmodule

bind dslice_buf dslice_buf_chk #(.OP_W(OP_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .ret_valid (ret_valid),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_op    (iss_op),
  .iss_seq   (iss_seq),
  .iss_val   (iss_val),
  .empty     (empty),
  .full      (full)
);

// File: tb/tb_dslice_buf.sv
module tb_dslice_buf;
  localparam int D = 32, TW = 4, OW = 16, SW = 8, VW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, enq_valid = 0, enq_is_load = 0, enq_has_val = 0;
  logic [TW-1:0] enq_tag = '0, ret_tag = '0;
  logic [OW-1:0] enq_op = '0;
  logic [SW-1:0] enq_seq = '0;
  logic [VW-1:0] enq_val = '0;
  logic ret_valid = 0, iss_ready = 0;
  logic enq_ready, iss_valid, iss_is_load, iss_has_val, empty, full;
  logic [TW-1:0] iss_tag;
  logic [OW-1:0] iss_op;
  logic [SW-1:0] iss_seq;
  logic [VW-1:0] iss_val;

  always #2.5 clk = ~clk;

  dslice_buf dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [OW-1:0] m_op [D];
  logic [SW-1:0] m_seq [D];
  logic [VW-1:0] m_val [D];
  logic [TW-1:0] m_tag [D];
  logic          m_ld [D];
  logic          m_hv [D];
  logic [15:0]   m_rdy;
  int m_head = 0, m_cnt = 0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic bit m_valid();
    return (m_cnt != 0) && (!m_ld[m_head] || m_rdy[m_tag[m_head]]);
  endfunction

  task automatic compare_all();
    chk("R4 iss_valid", 64'(iss_valid), 64'(m_valid()));
    chk("R11 empty", 64'(empty), 64'(m_cnt == 0));
    chk("R2 full", 64'(full), 64'(m_cnt == D));
    if (m_valid())
      chk("R3 head payload", {2'b0, iss_op, iss_seq, iss_has_val, iss_val, iss_is_load, iss_tag},
          {2'b0, m_op[m_head], m_seq[m_head], m_hv[m_head], m_val[m_head], m_ld[m_head], m_tag[m_head]});
  endtask

  task automatic step();
    bit fire, acc;
    int tail;
    fire = m_valid() && iss_ready;
    acc  = enq_valid && (m_cnt < D);
    tail = (m_head + m_cnt) % D;
    if (flush) begin
      m_cnt = 0; m_head = 0; m_rdy = '0;
    end else begin
      if (fire) begin
        if (m_ld[m_head]) m_rdy[m_tag[m_head]] = 1'b0;
        m_head = (m_head + 1) % D;
        m_cnt--;
      end
      if (acc) begin
        m_op[tail] = enq_op; m_seq[tail] = enq_seq; m_val[tail] = enq_val;
        m_tag[tail] = enq_tag; m_ld[tail] = enq_is_load; m_hv[tail] = enq_has_val;
        m_cnt++;
      end
      if (ret_valid) m_rdy[ret_tag] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic put(bit ld, logic [TW-1:0] t, logic [OW-1:0] o, logic [SW-1:0] s);
    enq_valid = 1; enq_is_load = ld; enq_tag = t; enq_op = o; enq_seq = s;
    enq_has_val = s[0]; enq_val = {o, 8'h5A, s};
  endtask

  task automatic idle();
    enq_valid = 0; ret_valid = 0; flush = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    logic [31:0] lf;
    m_rdy = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 empty", 64'(empty), 1); chk("R1 full", 64'(full), 0);
    chk("R1 iss_valid", 64'(iss_valid), 0); chk("R1 enq_ready", 64'(enq_ready), 1);

    // R7, R10
    put(0, 0, 16'h0101, 8'd1); step(); idle(); 
    chk("R7 dep head issues at once", 64'(iss_valid), 1);
    step(); step(); step();
    chk("R10 stalled valid", 64'(iss_valid), 1);
    chk("R10 stalled op", 64'(iss_op), 64'h0101);
    iss_ready = 1; step();
    chk("R11 empty after drain", 64'(empty), 1);

    // R4
    iss_ready = 0;
    put(1, 5, 16'h0200, 8'd2); step();
    put(0, 0, 16'h0201, 8'd3); step();
    put(1, 9, 16'h0300, 8'd4); step();
    put(0, 0, 16'h0301, 8'd5); step();
    idle(); iss_ready = 1;
    repeat (4) step();
    chk("R4 load head blocked", 64'(iss_valid), 0);

    // R5: later tag returns first
    ret_valid = 1; ret_tag = 9; step(); idle(); step();
    chk("R5 later return no bypass", 64'(iss_valid), 0);
    chk("R5 head still first load", 64'(iss_op), 64'h0200);

    // R6
    ret_valid = 1; ret_tag = 5; step(); idle();
    chk("R6 wake one cycle after return", 64'(iss_valid), 1);
    chk("R6 head tag", 64'(iss_tag), 5);
    step(); step();
    chk("R5 early-returned load issues at once", 64'(iss_valid), 1);
    chk("R5 head is second load", 64'(iss_op), 64'h0300);
    step(); step();
    chk("R11 empty after chains", 64'(empty), 1);

    // R9: tag 5 mark consumed
    put(1, 5, 16'h0400, 8'd6); step(); idle(); step();
    chk("R9 reused tag waits", 64'(iss_valid), 0);

    // R8
    ret_valid = 1; ret_tag = 3; step(); idle();
    flush = 1; put(0, 0, 16'h0500, 8'd7); step(); idle();
    chk("R8 flush empties", 64'(empty), 1);
    chk("R8 flush-cycle enqueue dropped", 64'(iss_valid), 0);
    put(1, 3, 16'h0600, 8'd8); step(); idle(); step();
    chk("R8 ready marks cleared", 64'(iss_valid), 0);
    flush = 1; step(); idle();

    // R9 same-cycle return on consume keeps mark
    ret_valid = 1; ret_tag = 7; step(); idle();
    put(1, 7, 16'h0700, 8'd9); step(); idle();
    ret_valid = 1; ret_tag = 7; step(); idle();
    put(1, 7, 16'h0701, 8'd10); step(); idle(); 
    chk("R9 return on consume keeps mark", 64'(iss_valid), 1);
    step();

    // R2 fill, overflow, drain in order (R3 by model)
    iss_ready = 0;
    for (int i = 0; i < D + 1; i++) begin
      put(0, 0, 16'(16'h1000 + i * 7), 8'(i)); step();
    end
    idle();
    chk("R2 full at depth", 64'(full), 1);
    chk("R2 enq_ready low", 64'(enq_ready), 0);
    put(0, 0, 16'hBEEF, 8'hEE); iss_ready = 1; step(); idle();
    chk("R2 enqueue refused on full with issue", 64'(full), 0);
    for (int i = 0; i < D - 1; i++) step();
    chk("R2 drained exactly depth", 64'(empty), 1);

    // pseudo-random mix (R3/R4/R5/R9 via model)
    lf = 32'h1ACE_B00C;
    for (int c = 0; c < 6000; c++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      enq_valid = lf[0] | lf[1];
      enq_is_load = lf[2] & lf[3];
      enq_tag = lf[7:4]; enq_op = lf[23:8]; enq_seq = lf[31:24];
      enq_has_val = lf[9]; enq_val = lf ^ 32'h3C3C_A5A5;
      ret_valid = lf[10] & lf[11]; ret_tag = lf[15:12];
      iss_ready = lf[16] | lf[17];
      flush = (lf[27:18] == 10'h3FF);
      step();
    end
    idle();
    summary();
  end
endmodule